// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a write-through cache and the next memory level and queues pending writes. Each slot holds one block: a block address, the block's data words and a byte-enable mask. A store to a block that already has a pending slot is folded into that slot instead of taking a new one. Stores into the I/O region are the exception and always get a slot of their own. A dirty block evicted from a write-back cache enters through the same port with every byte enabled, so it waits in the buffer like any other write.

Slots drain to memory oldest first, one write per accepted request, whenever the memory port is not busy with a read. A read miss takes priority over queued writes. When the read is accepted, every pending slot is compared with the read block address. Bytes held in matching slots are captured and later laid over the data returned by memory, so the read never sees a stale value even though it reaches memory ahead of older writes. The captured state is the buffer as it stood at acceptance, so a store accepted in the same cycle as the read, or later, counts as newer than the read. DEPTH must be a power of two and at least 2.

Top module: `merging_wbuf`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is 0, `st_full` is 0 and `rd_ready` is 1.
- R2: A store whose block address equals a pending slot that is not being handed to memory in that cycle updates only the bytes whose enables are set, ORs its enables into the slot, and takes no new slot.
- R3: Block addresses with bit 9 (the top bit) set are I/O. An I/O store never merges: each takes a slot of its own and is written to memory separately, in order.
- R4: `st_full` is 1 only when no mergeable slot matches `st_addr` and all DEPTH slots hold pending writes. A store presented while `st_full` is 1 is dropped and never reaches memory.
- R5: Pending writes are presented on the memory port with `mem_we`=1, oldest first, with their address, data and byte enables. Each cycle with `mem_valid` and `mem_ready` both high retires exactly one slot.
- R6: A read is accepted while `rd_ready` is 1. In the acceptance cycle no write is presented. In the next cycle the port presents the read (`mem_we`=0, `mem_addr`=`rd_addr`) even if writes are pending. No write is issued until the read data has returned.
- R7: When memory returns read data (`mem_rvalid` while waiting), `rd_resp_valid` is 1 in that same cycle. Each byte of `rd_resp_data` comes from the youngest matching pending slot with that byte enabled, as captured at acceptance, and otherwise from `mem_rdata`.
- R8: If a store matches the oldest slot in the same cycle that slot is handed to memory, the store takes a new slot and is written afterwards as a separate request. If the handoff does not happen that cycle, the store merges.
- R9: An evicted dirty block (all enables set) can be parked while a read to a different block is pending. The read is issued first and the parked block is written to memory after the read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store or evicted-block write present |
| st_addr | input | 10 | Block address of the write |
| st_data | input | 64 | Block data, word 0 in the low bits |
| st_be | input | 8 | Byte enables for the block |
| st_full | output | 1 | Store cannot be taken this cycle |
| rd_valid | input | 1 | Read miss request |
| rd_addr | input | 10 | Block address of the read |
| rd_ready | output | 1 | Read request can be accepted |
| rd_resp_valid | output | 1 | Read data is valid |
| rd_resp_data | output | 64 | Read block, with buffered bytes applied |
| mem_valid | output | 1 | Memory request present |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 10 | Memory block address |
| mem_wdata | output | 64 | Write data |
| mem_be | output | 8 | Write byte enables |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 64 | Read data from memory |

## Verification
The assertions assume that memory returns `mem_rvalid` only while a read is outstanding and only once per read. They also assume that `rd_valid` and `st_valid` are driven for a single cycle per request. The stimulus raises `mem_rvalid` for exactly one cycle after each read handshake and drops each request strobe right after its acceptance cycle. `mem_ready` is held low whenever slots must accumulate, so full and merge conditions arise only when a test sets them up.

// File: rtl/wbuf_pkg.sv
`timescale 1ns/1ps
package wbuf_pkg;
    localparam int AW      = 10;
    localparam int WORD_W  = 32;
    localparam int WORDS   = 2;
    localparam int BLK_W   = WORD_W * WORDS;
    localparam int BLK_B   = BLK_W / 8;

    typedef logic [AW-1:0]    baddr_t;
    typedef logic [BLK_W-1:0] blk_t;
    typedef logic [BLK_B-1:0] ben_t;

    typedef struct packed {
        logic   vld;
        baddr_t addr;
        blk_t   data;
        ben_t   be;
    } slot_t;

    typedef enum logic [1:0] {RS_IDLE, RS_REQ, RS_WAIT} rstate_t;

    // Overlay the enabled bytes of upd onto base
    function automatic blk_t byte_merge(blk_t base, blk_t upd, ben_t sel);
        blk_t r;
        r = base;
        for (int b = 0; b < BLK_B; b++)
            if (sel[b]) r[b*8 +: 8] = upd[b*8 +: 8];
        return r;
    endfunction

    function automatic logic is_io(baddr_t a);
        return a[AW-1];
    endfunction
endpackage

// File: rtl/wbuf_store.sv
`timescale 1ns/1ps
module wbuf_store
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_valid,
    input  baddr_t              wr_addr,
    input  blk_t                wr_data,
    input  ben_t                wr_be,
    input  logic                drain_fire,
    output logic                wr_full,
    output slot_t               head_slot,
    output slot_t [DEPTH-1:0]   slots,
    output logic [PW-1:0]       head_idx
);
    slot_t [DEPTH-1:0] slot_q;
    logic [PW-1:0]     hd_q, tl_q;
    logic [CW-1:0]     cnt_q;
    logic              hit;
    logic [PW-1:0]     hit_idx;
    logic              do_merge, do_alloc;

    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_q[i].vld && slot_q[i].addr == wr_addr && !is_io(wr_addr)
                && !(drain_fire && PW'(i) == hd_q)) begin
                hit     = 1'b1;
                hit_idx = PW'(i);
            end
        end
    end

    assign wr_full   = !hit && (cnt_q == CW'(DEPTH));
    assign do_merge  = wr_valid && hit;
    assign do_alloc  = wr_valid && !hit && (cnt_q != CW'(DEPTH));
    assign head_slot = slot_q[hd_q];
    assign slots     = slot_q;
    assign head_idx  = hd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            hd_q   <= '0;
            tl_q   <= '0;
            cnt_q  <= '0;
        end else begin
            if (drain_fire) begin
                slot_q[hd_q].vld <= 1'b0;
                hd_q <= hd_q + 1'b1;
            end
            if (do_merge) begin
                slot_q[hit_idx].data <= byte_merge(slot_q[hit_idx].data, wr_data, wr_be);
                slot_q[hit_idx].be   <= slot_q[hit_idx].be | wr_be;
            end
            if (do_alloc) begin
                slot_q[tl_q] <= '{vld: 1'b1, addr: wr_addr, data: wr_data, be: wr_be};
                tl_q <= tl_q + 1'b1;
            end
            cnt_q <= cnt_q + CW'(do_alloc) - CW'(drain_fire);
        end
    end

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_full && !drain_fire) |=> cnt_q == $past(cnt_q));

    // R5
    drain_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_fire && !wr_valid) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R3
    io_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_full && is_io(wr_addr) && !drain_fire) |=> cnt_q == $past(cnt_q) + 1'b1);

    // R8
    head_race_chk: assert property (@(posedge clk) disable iff (rst)
        (drain_fire && wr_valid && wr_addr == head_slot.addr && !is_io(wr_addr))
        |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/wbuf_fwd.sv
`timescale 1ns/1ps
module wbuf_fwd
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = $clog2(DEPTH)
) (
    input  slot_t [DEPTH-1:0] slots,
    input  logic [PW-1:0]     head_idx,
    input  baddr_t            look_addr,
    output blk_t              fwd_data,
    output ben_t              fwd_be
);
    // Walk oldest to youngest so younger bytes win
    always_comb begin
        logic [PW-1:0] idx;
        fwd_data = '0;
        fwd_be   = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head_idx + PW'(k);
            if (slots[idx].vld && slots[idx].addr == look_addr) begin
                fwd_data = byte_merge(fwd_data, slots[idx].data, slots[idx].be);
                fwd_be   = fwd_be | slots[idx].be;
            end
        end
    end
endmodule

// File: rtl/wbuf_rdctl.sv
`timescale 1ns/1ps
module wbuf_rdctl
    import wbuf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   rd_valid,
    input  baddr_t rd_addr,
    input  blk_t   fwd_data,
    input  ben_t   fwd_be,
    input  slot_t  head_slot,
    input  logic   mem_ready,
    input  logic   mem_rvalid,
    input  blk_t   mem_rdata,
    output logic   rd_ready,
    output logic   rd_resp_valid,
    output blk_t   rd_resp_data,
    output logic   mem_valid,
    output logic   mem_we,
    output baddr_t mem_addr,
    output blk_t   mem_wdata,
    output ben_t   mem_be,
    output logic   drain_fire
);
    rstate_t st_q;
    baddr_t  ra_q;
    blk_t    fd_q;
    ben_t    fb_q;

    assign rd_ready = (st_q == RS_IDLE);

    always_comb begin
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ra_q;
        mem_wdata = '0;
        mem_be    = '0;
        case (st_q)
            RS_IDLE: begin
                mem_valid = head_slot.vld && !rd_valid;
                mem_we    = 1'b1;
                mem_addr  = head_slot.addr;
                mem_wdata = head_slot.data;
                mem_be    = head_slot.be;
            end
            RS_REQ:  mem_valid = 1'b1;
            default: mem_valid = 1'b0;
        endcase
    end

    assign drain_fire    = (st_q == RS_IDLE) && mem_valid && mem_ready;
    assign rd_resp_valid = (st_q == RS_WAIT) && mem_rvalid;
    assign rd_resp_data  = byte_merge(mem_rdata, fd_q, fb_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RS_IDLE;
            ra_q <= '0;
            fd_q <= '0;
            fb_q <= '0;
        end else begin
            case (st_q)
                RS_IDLE: if (rd_valid) begin
                    st_q <= RS_REQ;
                    ra_q <= rd_addr;
                    fd_q <= fwd_data;
                    fb_q <= fwd_be;
                end
                RS_REQ:  if (mem_ready)  st_q <= RS_WAIT;
                RS_WAIT: if (mem_rvalid) st_q <= RS_IDLE;
                default: st_q <= RS_IDLE;
            endcase
        end
    end

    // R6
    rd_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> (mem_valid && !mem_we && mem_addr == $past(rd_addr)));

    // R6
    no_wr_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_ready |-> !(mem_valid && mem_we));

    // R7
    resp_once_chk: assert property (@(posedge clk) disable iff (rst)
        rd_resp_valid |=> rd_ready);
endmodule

// File: rtl/merging_wbuf.sv
`timescale 1ns/1ps
module merging_wbuf
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              st_valid,
    input  logic [AW-1:0]     st_addr,
    input  logic [BLK_W-1:0]  st_data,
    input  logic [BLK_B-1:0]  st_be,
    output logic              st_full,
    input  logic              rd_valid,
    input  logic [AW-1:0]     rd_addr,
    output logic              rd_ready,
    output logic              rd_resp_valid,
    output logic [BLK_W-1:0]  rd_resp_data,
    output logic              mem_valid,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    output logic [BLK_B-1:0]  mem_be,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [BLK_W-1:0]  mem_rdata
);
    localparam int PW = $clog2(DEPTH);

    slot_t             head_slot;
    slot_t [DEPTH-1:0] slots;
    logic [PW-1:0]     head_idx;
    logic              drain_fire;
    blk_t              fwd_data;
    ben_t              fwd_be;

    wbuf_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_valid(st_valid), .wr_addr(st_addr), .wr_data(st_data), .wr_be(st_be),
        .drain_fire(drain_fire), .wr_full(st_full),
        .head_slot(head_slot), .slots(slots), .head_idx(head_idx)
    );

    wbuf_fwd #(.DEPTH(DEPTH)) u_fwd (
        .slots(slots), .head_idx(head_idx), .look_addr(rd_addr),
        .fwd_data(fwd_data), .fwd_be(fwd_be)
    );

    wbuf_rdctl u_rdctl (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_addr(rd_addr),
        .fwd_data(fwd_data), .fwd_be(fwd_be), .head_slot(head_slot),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .rd_ready(rd_ready), .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .drain_fire(drain_fire)
    );

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> (rd_ready && !mem_valid));
endmodule

// File: tb/tb_merging_wbuf.sv
`timescale 1ns/1ps
module tb_merging_wbuf;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 1'b0;
    logic [9:0]  st_addr = '0;
    logic [63:0] st_data = '0;
    logic [7:0]  st_be = '0;
    logic        st_full;
    logic        rd_valid = 1'b0;
    logic [9:0]  rd_addr = '0;
    logic        rd_ready;
    logic        rd_resp_valid;
    logic [63:0] rd_resp_data;
    logic        mem_valid, mem_we;
    logic [9:0]  mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0]  mem_be;
    logic        mem_ready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    int n_tests = 0;
    int n_fail  = 0;
    logic [9:0]  log_addr [32];
    logic [63:0] log_data [32];
    logic [7:0]  log_be   [32];
    int nlog = 0;

    always #4 clk = ~clk;

    merging_wbuf #(.DEPTH(4)) dut (
        .clk(clk), .rst(rst),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_full(st_full),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be),
        .mem_ready(mem_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    localparam int NST = 7;
    localparam logic [9:0]  T_ADDR [NST] = '{10'h010, 10'h020, 10'h010, 10'h210, 10'h210, 10'h020, 10'h030};
    localparam logic [63:0] T_DATA [NST] = '{64'h0000_0000_A1A2_A3A4, 64'hB1B2_B3B4_0000_0000,
                                             64'h0000_C3C4_0000_00C5, 64'h0000_0000_0000_00D1,
                                             64'h0000_0000_0000_00E1, 64'h0000_0000_0000_00F1,
                                             64'h0000_0000_0000_0077};
    localparam logic [7:0]  T_BE   [NST] = '{8'h0F, 8'hF0, 8'h31, 8'h01, 8'h01, 8'h01, 8'hFF};
    localparam logic        T_FULL [NST] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    localparam int ND = 4;
    localparam logic [9:0]  D_ADDR [ND] = '{10'h010, 10'h020, 10'h210, 10'h210};
    localparam logic [63:0] D_DATA [ND] = '{64'h0000_C3C4_A1A2_A3C5, 64'hB1B2_B3B4_0000_00F1,
                                            64'h0000_0000_0000_00D1, 64'h0000_0000_0000_00E1};
    localparam logic [7:0]  D_BE   [ND] = '{8'h3F, 8'hF1, 8'h01, 8'h01};

    function automatic logic [63:0] bmask(logic [7:0] be);
        logic [63:0] m;
        for (int b = 0; b < 8; b++) m[b*8 +: 8] = {8{be[b]}};
        return m;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_log(string req, int idx, logic [9:0] a, logic [63:0] d, logic [7:0] be);
        check(req, {54'd0, log_addr[idx]}, {54'd0, a});
        check(req, {56'd0, log_be[idx]}, {56'd0, be});
        check(req, log_data[idx] & bmask(be), d & bmask(be));
    endtask

    // Let combinational outputs settle, record a write handshake, move to next negedge
    task automatic tick();
        #1;
        if (mem_valid && mem_ready && mem_we) begin
            log_addr[nlog] = mem_addr;
            log_data[nlog] = mem_wdata;
            log_be[nlog]   = mem_be;
            nlog++;
        end
        @(negedge clk);
    endtask

    task automatic store(logic [9:0] a, logic [63:0] d, logic [7:0] be);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
        tick();
        st_valid = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int base;
        @(negedge clk); @(negedge clk); @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 mem_valid", {63'd0, mem_valid}, 64'd0);
        check("R1 st_full",   {63'd0, st_full},   64'd0);
        check("R1 rd_ready",  {63'd0, rd_ready},  64'd1);
        @(negedge clk);

        // Table walk: R2 merge, R3 I/O no merge, R4 full
        for (int i = 0; i < NST; i++) begin
            st_valid = 1'b1; st_addr = T_ADDR[i]; st_data = T_DATA[i]; st_be = T_BE[i];
            #1;
            check("R4 st_full", {63'd0, st_full}, {63'd0, T_FULL[i]});
            tick();
        end
        st_valid = 1'b0;
        #1;
        // R5 oldest presented first
        check("R5 head addr", {54'd0, mem_addr}, {54'd0, 10'h010});
        check("R5 head we",   {63'd0, mem_we},   64'd1);
        base = nlog;
        mem_ready = 1'b1;
        for (int i = 0; i < 6; i++) tick();
        check("R4 drop count", 64'(nlog - base), 64'(ND));
        for (int i = 0; i < ND; i++) check_log("R2 R3 R5 drain", base + i, D_ADDR[i], D_DATA[i], D_BE[i]);
        #1;
        check("R5 empty", {63'd0, mem_valid}, 64'd0);
        @(negedge clk);

        // R8: store racing the handoff of its slot takes a new slot
        mem_ready = 1'b0;
        base = nlog;
        store(10'h040, 64'h0000_0000_1122_3344, 8'h0F);
        st_valid = 1'b1; st_addr = 10'h040; st_data = 64'h5566_7788_0000_0000; st_be = 8'hF0;
        mem_ready = 1'b1;
        tick();
        st_valid = 1'b0;
        tick(); tick();
        check("R8 race count", 64'(nlog - base), 64'd2);
        check_log("R8 first", base,     10'h040, 64'h0000_0000_1122_3344, 8'h0F);
        check_log("R8 second", base + 1, 10'h040, 64'h5566_7788_0000_0000, 8'hF0);

        // R8 / R2: without handoff the same pair merges
        mem_ready = 1'b0;
        base = nlog;
        store(10'h050, 64'h0000_0000_0A0B_0C0D, 8'h0F);
        store(10'h050, 64'h0E0F_1011_0000_0000, 8'hF0);
        mem_ready = 1'b1;
        tick(); tick(); tick();
        check("R8 merge count", 64'(nlog - base), 64'd1);
        check_log("R2 merged", base, 10'h050, 64'h0E0F_1011_0A0B_0C0D, 8'hFF);

        // R6 R7 R9: partial slot plus parked evicted block, reads go first
        mem_ready = 1'b0;
        store(10'h060, 64'h0000_0000_BC9A_0000, 8'h0C);
        store(10'h070, 64'h0123_4567_89AB_CDEF, 8'hFF);
        base = nlog;
        rd_valid = 1'b1; rd_addr = 10'h060;
        #1;
        check("R6 accept ready", {63'd0, rd_ready}, 64'd1);
        check("R6 no write at accept", {63'd0, mem_valid}, 64'd0);
        tick();
        rd_valid = 1'b0;
        #1;
        check("R6 read issued", {62'd0, mem_valid, mem_we}, 64'd2);
        check("R6 read addr", {54'd0, mem_addr}, {54'd0, 10'h060});
        mem_ready = 1'b1;
        tick();
        #1;
        check("R6 no write while waiting", {63'd0, mem_valid}, 64'd0);
        mem_rvalid = 1'b1; mem_rdata = 64'hFFEE_DDCC_BBAA_9988;
        #1;
        check("R7 resp valid", {63'd0, rd_resp_valid}, 64'd1);
        check("R7 partial forward", rd_resp_data, 64'hFFEE_DDCC_BC9A_9988);
        tick();
        mem_rvalid = 1'b0;
        rd_valid = 1'b1; rd_addr = 10'h070;
        tick();
        rd_valid = 1'b0;
        tick();
        mem_rvalid = 1'b1; mem_rdata = 64'h0;
        #1;
        check("R7 full forward", rd_resp_data, 64'h0123_4567_89AB_CDEF);
        tick();
        mem_rvalid = 1'b0;
        check("R9 no write during reads", 64'(nlog - base), 64'd0);
        tick(); tick(); tick();
        check("R9 writes after read", 64'(nlog - base), 64'd2);
        check_log("R9 partial slot", base,     10'h060, 64'h0000_0000_BC9A_0000, 8'h0C);
        check_log("R9 evicted block", base + 1, 10'h070, 64'h0123_4567_89AB_CDEF, 8'hFF);

        // R7 no match: data straight from memory
        rd_valid = 1'b1; rd_addr = 10'h080;
        tick();
        rd_valid = 1'b0;
        tick();
        mem_rvalid = 1'b1; mem_rdata = 64'h1357_9BDF_2468_ACE0;
        #1;
        check("R7 no match", rd_resp_data, 64'h1357_9BDF_2468_ACE0);
        tick();
        mem_rvalid = 1'b0;
        tick();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule